// File: doc/BRIEF.md
# DDR burst read data launcher

This block is the read-side output sequencer of a double-data-rate graphics memory device model. When a READ command is sampled, the block waits a programmable CAS latency. It then frames a four-word burst on a data strobe and a data bus. The strobe first goes low for a preamble, then shows two clock cycles of double-rate data, and then goes low for a half-cycle postamble before it is released.

The whole block runs on one clock. Each double-rate signal is split into two lanes: a rising-half lane that holds during the first half of the clock cycle, and a falling-half lane that holds during the second half. Two words are fetched from the internal array in each data cycle through a pair of combinational read ports, one per lane. Output enables stand in for a high-impedance pad.

Top module: `ddr_rd_launcher`

## Requirements
- R1: A READ is taken when `cmd_read` is high at a rising edge while no burst is active. Cycles with `cmd_read` low are NOPs and leave a running burst alone. The CAS latency CL comes from `cas_mode`: code 0 gives 2, code 1 gives 3, and codes 2 and 3 give 4. Counting the sampling edge's cycle as cycle 0, the first data cycle is cycle CL.
- R2: With no burst active, `dqs_oe_r`, `dqs_oe_f`, `dqs_r`, `dqs_f` and `dq_oe` are 0 and `dq_r`/`dq_f` are all zero. The same holds during reset.
- R3: In cycle CL-1 (the preamble), `dqs_oe_r` and `dqs_oe_f` are 1, `dqs_r` and `dqs_f` are 0, and `dq_oe` is 0.
- R4: In cycles CL and CL+1, both strobe enables and `dq_oe` are 1, with `dqs_r`=1 and `dqs_f`=0. `dq_r` carries beats 0 and 2, and `dq_f` carries beats 1 and 3.
- R5: Beat i reads column {col[7:2], (col[1:0]+i) mod 4}, where col is the sampled start column. The word driven is the array word returned on `rd_data_r`/`rd_data_f` for `rd_addr_r`/`rd_addr_f`.
- R6: In cycle CL+2 (the postamble), `dqs_oe_r`=1, `dqs_r`=0, `dqs_oe_f`=0 and `dq_oe`=0. From cycle CL+3 the outputs are idle and a new READ can be taken.
- R7: A READ sampled in cycles 1 to CL+2 of a burst is ignored and does not alter the burst. `rd_err` goes high for exactly the one cycle after that sampling edge.
- R8: `cas_mode` is sampled only with an accepted READ. Changing it during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_read | input | 1 | READ command (low = NOP) |
| col_addr | input | AW | Start column of the burst |
| cas_mode | input | 2 | CAS latency code (0:2, 1:3, 2/3:4) |
| rd_addr_r | output | AW | Array address for the rising-half word |
| rd_addr_f | output | AW | Array address for the falling-half word |
| rd_data_r | input | DW | Array word for `rd_addr_r` |
| rd_data_f | input | DW | Array word for `rd_addr_f` |
| dqs_oe_r | output | 1 | Strobe enable, rising half |
| dqs_oe_f | output | 1 | Strobe enable, falling half |
| dqs_r | output | 1 | Strobe value, rising half |
| dqs_f | output | 1 | Strobe value, falling half |
| dq_oe | output | 1 | Data bus enable |
| dq_r | output | DW | Data word, rising half |
| dq_f | output | DW | Data word, falling half |
| rd_err | output | 1 | One-cycle flag for an ignored READ |

## Verification
A wrong latency latch or cycle counter shifts the preamble, data or postamble cycle. It shows on the strobe enables within CL-1 cycles of the READ, and every later phase of the burst then disagrees too. A corrupted start column or beat offset shows as a wrong word on `dq_r` or `dq_f` in the first or second data cycle. A busy flag that stays set or clears early shows either as a missing next burst or as `rd_err` misbehaving on the READ issued at the boundary cycle CL+2 or CL+3.

// File: rtl/ddr_rd_launcher.sv
module ddr_rd_launcher #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_read,
  input  logic [AW-1:0] col_addr,
  input  logic [1:0]    cas_mode,
  output logic [AW-1:0] rd_addr_r,
  output logic [AW-1:0] rd_addr_f,
  input  logic [DW-1:0] rd_data_r,
  input  logic [DW-1:0] rd_data_f,
  output logic          dqs_oe_r,
  output logic          dqs_oe_f,
  output logic          dqs_r,
  output logic          dqs_f,
  output logic          dq_oe,
  output logic [DW-1:0] dq_r,
  output logic [DW-1:0] dq_f,
  output logic          rd_err
);
  localparam int CW = 3;

  logic          busy;
  logic [CW-1:0] cnt, lat;
  logic [AW-1:0] col;
  logic          ph_pre, ph_d0, ph_d1, ph_post;
  logic [CW-1:0] lat_in;

  assign lat_in  = (cas_mode == 2'd0) ? 3'd2 : (cas_mode == 2'd1) ? 3'd3 : 3'd4;

  assign ph_pre  = busy && (cnt == lat - 3'd1);
  assign ph_d0   = busy && (cnt == lat);
  assign ph_d1   = busy && (cnt == lat + 3'd1);
  assign ph_post = busy && (cnt == lat + 3'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      lat    <= 3'd2;
      col    <= '0;
      rd_err <= 1'b0;
    end else begin
      rd_err <= cmd_read && busy;
      if (!busy) begin
        if (cmd_read) begin
          busy <= 1'b1;
          cnt  <= 3'd1;
          lat  <= lat_in;
          col  <= col_addr;
        end
      end else if (ph_post) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 3'd1;
      end
    end
  end

  assign rd_addr_r = {col[AW-1:2], col[1:0] + {ph_d1, 1'b0}};
  assign rd_addr_f = {col[AW-1:2], col[1:0] + {ph_d1, 1'b1}};

  assign dq_oe    = ph_d0 | ph_d1;
  assign dqs_oe_f = ph_pre | dq_oe;
  assign dqs_oe_r = dqs_oe_f | ph_post;
  assign dqs_r    = dq_oe;
  assign dqs_f    = 1'b0;
  assign dq_r     = dq_oe ? rd_data_r : '0;
  assign dq_f     = dq_oe ? rd_data_f : '0;
endmodule

// File: rtl/ddr_rd_launcher_chk.sv
module ddr_rd_launcher_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_read,
  input logic          dqs_oe_r,
  input logic          dqs_oe_f,
  input logic          dqs_r,
  input logic          dq_oe,
  input logic [AW-1:0] rd_addr_r,
  input logic [AW-1:0] rd_addr_f,
  input logic          rd_err
);
  a_r4_data_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dqs_oe_r && dqs_oe_f && dqs_r));

  a_r3_preamble_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(dqs_oe_r && dqs_oe_f && !dqs_r && !dq_oe));

  a_r4_two_data_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |=> dq_oe);

  a_r4_no_third_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |=> !dq_oe);

  a_r6_postamble: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (dqs_oe_r && !dqs_oe_f && !dqs_r));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_oe_r && !dqs_oe_f) |=> !dqs_oe_r);

  a_r5_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (rd_addr_f[AW-1:2] == rd_addr_r[AW-1:2] &&
               rd_addr_f[1:0] == rd_addr_r[1:0] + 2'd1));

  a_r7_err_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(cmd_read));
endmodule

bind ddr_rd_launcher ddr_rd_launcher_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_read(cmd_read),
  .dqs_oe_r(dqs_oe_r), .dqs_oe_f(dqs_oe_f), .dqs_r(dqs_r), .dq_oe(dq_oe),
  .rd_addr_r(rd_addr_r), .rd_addr_f(rd_addr_f), .rd_err(rd_err)
);

// File: tb/ddr_rd_launcher_tb_top.sv
module ddr_rd_launcher_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, cmd_read = 1'b0;
  logic [7:0]  col_addr = '0;
  logic [1:0]  cas_mode = '0;
  logic [7:0]  rd_addr_r, rd_addr_f;
  logic [31:0] rd_data_r, rd_data_f, dq_r, dq_f;
  logic        dqs_oe_r, dqs_oe_f, dqs_r, dqs_f, dq_oe, rd_err;

  function automatic logic [31:0] memw(input logic [7:0] a);
    return {a, ~a, a ^ 8'h3C, a + 8'h11};
  endfunction

  assign rd_data_r = memw(rd_addr_r);
  assign rd_data_f = memw(rd_addr_f);

  ddr_rd_launcher #(.DW(32), .AW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_read(cmd_read), .col_addr(col_addr),
    .cas_mode(cas_mode), .rd_addr_r(rd_addr_r), .rd_addr_f(rd_addr_f),
    .rd_data_r(rd_data_r), .rd_data_f(rd_data_f), .dqs_oe_r(dqs_oe_r),
    .dqs_oe_f(dqs_oe_f), .dqs_r(dqs_r), .dqs_f(dqs_f), .dq_oe(dq_oe),
    .dq_r(dq_r), .dq_f(dq_f), .rd_err(rd_err)
  );

  typedef struct {int issue; int lat; logic [7:0] col;} burst_t;
  burst_t bq[$];
  int     err_q[$];
  int     edge_cnt = 0, vectors = 0, miscomp = 0;
  int     last_issue = 0, last_lat = 0;
  bit     have_last = 1'b0, finished = 1'b0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  function automatic logic [7:0] beat_col(input logic [7:0] c, input int i);
    return {c[7:2], c[1:0] + 2'(i)};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic issue(input logic [7:0] c, input logic [1:0] code);
    int L;
    @(posedge clk); #1;
    cmd_read = 1'b1; col_addr = c; cas_mode = code;
    L = (code == 2'd0) ? 2 : (code == 2'd1) ? 3 : 4;
    if (!have_last || (edge_cnt - last_issue) > last_lat + 2) begin
      bq.push_back('{edge_cnt, L, c});
      have_last = 1'b1; last_issue = edge_cnt; last_lat = L;
    end else begin
      err_q.push_back(edge_cnt + 1);
    end
    @(posedge clk); #1;
    cmd_read = 1'b0;
  endtask

  logic [69:0] act_v, exp_v;
  logic        e_oer, e_oef, e_dqsr, e_dqoe, e_err;
  logic [31:0] e_dqr, e_dqf;
  string       tag;
  int          k, L;
  bit          pop_now;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      e_oer = 0; e_oef = 0; e_dqsr = 0; e_dqoe = 0; e_dqr = '0; e_dqf = '0;
      tag = "R2"; pop_now = 0;
      if (bq.size() > 0) begin
        k = edge_cnt - bq[0].issue;
        L = bq[0].lat;
        if (k == L - 1) begin
          e_oer = 1; e_oef = 1; tag = "R3";
        end else if (k == L || k == L + 1) begin
          e_oer = 1; e_oef = 1; e_dqsr = 1; e_dqoe = 1;
          e_dqr = memw(beat_col(bq[0].col, (k == L) ? 0 : 2));
          e_dqf = memw(beat_col(bq[0].col, (k == L) ? 1 : 3));
          tag = "R1 R4 R5 R8";
        end else if (k == L + 2) begin
          e_oer = 1; tag = "R6"; pop_now = 1;
        end
      end
      e_err = (err_q.size() > 0 && err_q[0] == edge_cnt);
      if (e_err) void'(err_q.pop_front());
      act_v = {dqs_oe_r, dqs_oe_f, dqs_r, dqs_f, dq_oe, rd_err, dq_r, dq_f};
      exp_v = {e_oer, e_oef, e_dqsr, 1'b0, e_dqoe, e_err, e_dqr, e_dqf};
      vectors++;
      if (act_v !== exp_v) begin
        miscomp++;
        if (rd_err !== e_err) tag = "R7";
        $display("FAIL %s at edge %0d: got %h expected %h", tag, edge_cnt, act_v, exp_v);
      end
      if (pop_now) void'(bq.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if ({dqs_oe_r, dqs_oe_f, dqs_r, dqs_f, dq_oe, rd_err, dq_r, dq_f} !== 70'd0) begin
      miscomp++;
      $display("FAIL R2 reset: got %h expected 0",
               {dqs_oe_r, dqs_oe_f, dqs_r, dqs_f, dq_oe, rd_err, dq_r, dq_f});
    end
    @(posedge clk); #1 rst_n = 1'b1;
    issue(8'h10, 2'd0); idle(8);
    issue(8'h47, 2'd1); idle(9);
    issue(8'hFE, 2'd2); idle(10);
    issue(8'h83, 2'd3); idle(10);
    // R8: mode changed right after the accepting edge
    issue(8'h21, 2'd1); cas_mode = 2'd2; idle(2); cas_mode = 2'd0; idle(8);
    // R7: READ in data cycle of a running burst
    issue(8'h30, 2'd0); issue(8'h99, 2'd2); idle(10);
    // R7: READ in the postamble cycle is ignored
    issue(8'h34, 2'd0); idle(2); issue(8'h55, 2'd1); idle(10);
    // R6: READ in the cycle after the postamble is accepted
    issue(8'h40, 2'd0); idle(3); issue(8'h6A, 2'd1); idle(12);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      miscomp++;
      $display("FAIL R1 watchdog expired: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end
endmodule